// File: doc/BRIEF.md
# Cell Command Packet Receiver

This block lives in every power cell of a cascaded converter and turns the byte stream from the cell's serial receiver into PWM compare settings. Bytes arrive one per handshake on a valid/ready input. The block groups them into fixed six-byte command packets and computes a running CRC-8 over each packet. It loads two 16-bit switch compare values only when a packet's CRC and address are both correct. On that same event it emits a one-cycle strobe that the cell's carrier generators use to realign to the central controller's timing.

If the serial line goes quiet in the middle of a packet for longer than a programmable number of cycles, the partial packet is discarded and framing restarts at byte zero. The block also produces the cell's two-byte reply to the central controller on a valid/ready output. When the cell's control logic pulses a request, the block sends its own address and then a DC-bus status byte.

Back-pressure rules: the input port never stalls, and `in_ready` is tied high because a serial receiver cannot hold a byte back. The reply port holds each byte and its valid flag steady until the consumer accepts it.

Top module: `cellcmd_rx`

## Requirements
- R1: Bytes are accepted on every cycle where `in_valid` is high (`in_ready` is always 1). A packet is six bytes, in this order: address, compare-A high, compare-A low, compare-B high, compare-B low, CRC.
- R2: The CRC is CRC-8 with polynomial 0x07, initial value 0x00, no reflection and no final XOR. It is computed MSB first over the first five bytes, and a packet is good only if the result equals the sixth byte.
- R3: A packet whose address byte differs from `my_addr` changes no output.
- R4: A packet that fails the CRC or the address test leaves `cmp_a` and `cmp_b` unchanged and raises no strobe. The next byte is taken as byte 0 of a new packet.
- R5: For a good packet, `cmp_a` = {byte1, byte2} and `cmp_b` = {byte3, byte4}. Both change together in the cycle after the sixth byte is accepted, and at no other time.
- R6: `sync_pulse` is high for exactly one cycle per good packet, in the same cycle the new compare values first appear.
- R7: While a packet is partly received, up to `gap_limit` idle cycles between bytes are tolerated. On the next idle cycle after that, the partial packet is discarded and framing returns to byte 0.
- R8: A reply request while the reply port is idle captures `my_addr` and `dc_status`. From the next cycle the port presents the address byte, then the status byte. Each byte holds, with `rpl_valid` high, until accepted with `rpl_ready`.
- R9: A reply request while a reply is still in progress, including in the cycle its last byte is accepted, is ignored.
- R10: After reset, `cmp_a` and `cmp_b` are 0, `sync_pulse` and `rpl_valid` are 0, and framing starts at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| my_addr | input | 8 | This cell's address |
| gap_limit | input | 16 | Idle cycles tolerated between bytes of one packet |
| in_valid | input | 1 | Received byte valid |
| in_ready | output | 1 | Always 1: byte accepted |
| in_data | input | 8 | Received byte |
| cmp_a | output | 16 | Compare value for the first upper switch |
| cmp_b | output | 16 | Compare value for the second upper switch |
| sync_pulse | output | 1 | One-cycle carrier realignment strobe |
| rpl_req | input | 1 | Request to send the status reply |
| dc_status | input | 8 | DC-bus status to report |
| rpl_valid | output | 1 | Reply byte valid |
| rpl_ready | input | 1 | Reply byte accepted |
| rpl_data | output | 8 | Reply byte |

## Verification
The bench targets four failure modes:
- Packets with one flipped CRC bit or a neighbouring address. A design that skipped either test would load garbage compare values and pulse the strobe.
- Gaps of exactly the limit and one cycle beyond it. An off-by-one timeout would either split a legal packet or glue a stale partial onto the next one, misaligning every later packet.
- A reply request issued while the reply port is stalled, and again on the final handshake. A design that restarted on it would send three or more bytes or drop the status.
- Strobe timing. A strobe shifted by a cycle from the compare update would show up on the clock-by-clock comparison against the model.

// File: rtl/cellcmd_pkg.sv
package cellcmd_pkg;

  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CRC_POLY = 8'h07;
  localparam logic [BYTE_W-1:0] CRC_SEED = 8'h00;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    RPL_IDLE = 2'd0,
    RPL_ADDR = 2'd1,
    RPL_STAT = 2'd2
  } rpl_state_e;

  // One byte through an MSB-first CRC-8 register.
  function automatic byte_t crc8_next(input byte_t crc, input byte_t din);
    byte_t c;
    c = crc ^ din;
    for (int i = 0; i < BYTE_W; i++) begin
      c = c[BYTE_W-1] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/cellcmd_framer.sv
module cellcmd_framer
  import cellcmd_pkg::*;
#(
  parameter int PKT_LEN = 6,
  parameter int GAP_W   = 16,
  localparam int IDX_W  = $clog2(PKT_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [GAP_W-1:0] gap_limit,
  output logic [IDX_W-1:0] pos_q,
  output logic             is_last
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_LEN - 1);

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      gap_q <= '0;
    end else if (in_valid) begin
      gap_q <= '0;
      pos_q <= (pos_q == LAST_IDX) ? '0 : pos_q + 1'b1;
    end else if (pos_q != '0) begin
      if (gap_q == gap_limit) begin
        pos_q <= '0;
        gap_q <= '0;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  assign is_last = in_valid && (pos_q == LAST_IDX);

  p_pos_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST_IDX);

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    is_last |=> (pos_q == '0));

  p_gap_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && pos_q != '0 && gap_q == gap_limit) |=> (pos_q == '0));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == '0 && !in_valid) |=> (pos_q == '0));

endmodule

// File: rtl/cellcmd_crc.sv
module cellcmd_crc
  import cellcmd_pkg::*;
#(
  parameter int PKT_LEN = 6,
  localparam int IDX_W  = $clog2(PKT_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] pos,
  input  byte_t            din,
  output logic             crc_ok
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_LEN - 1);

  byte_t crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
    end else if (in_valid && pos != LAST_IDX) begin
      crc_q <= crc8_next((pos == '0) ? CRC_SEED : crc_q, din);
    end
  end

  // Valid only while the CRC byte itself is on din.
  assign crc_ok = (crc_q == din);

endmodule

// File: rtl/cellcmd_stage.sv
module cellcmd_stage
  import cellcmd_pkg::*;
#(
  parameter int CMP_W   = 16,
  localparam int CMP_BYTES = CMP_W / BYTE_W,
  localparam int PKT_LEN   = 2 + 2 * CMP_BYTES,
  localparam int IDX_W     = $clog2(PKT_LEN),
  localparam int STG_N     = 2 * CMP_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] pos,
  input  byte_t            din,
  input  logic             is_last,
  input  logic             crc_ok,
  input  byte_t            my_addr,
  output logic [CMP_W-1:0] cmp_a_q,
  output logic [CMP_W-1:0] cmp_b_q,
  output logic             sync_q
);

  byte_t            addr_q;
  byte_t            stg_q [STG_N];
  logic [CMP_W-1:0] cmp_a_stg;
  logic [CMP_W-1:0] cmp_b_stg;
  logic             pkt_good;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      for (int i = 0; i < STG_N; i++) stg_q[i] <= '0;
    end else if (in_valid) begin
      if (pos == '0) addr_q <= din;
      for (int i = 0; i < STG_N; i++) begin
        if (pos == IDX_W'(i + 1)) stg_q[i] <= din;
      end
    end
  end

  // Big-endian assembly of each staged compare value.
  for (genvar g = 0; g < CMP_BYTES; g++) begin : g_asm
    assign cmp_a_stg[CMP_W-1-BYTE_W*g -: BYTE_W] = stg_q[g];
    assign cmp_b_stg[CMP_W-1-BYTE_W*g -: BYTE_W] = stg_q[CMP_BYTES+g];
  end

  assign pkt_good = is_last && crc_ok && (addr_q == my_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_a_q <= '0;
      cmp_b_q <= '0;
      sync_q  <= 1'b0;
    end else begin
      sync_q <= pkt_good;
      if (pkt_good) begin
        cmp_a_q <= cmp_a_stg;
        cmp_b_q <= cmp_b_stg;
      end
    end
  end

  p_hold_unless_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_q |-> ($stable(cmp_a_q) && $stable(cmp_b_q)));

  p_sync_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |=> !sync_q);

  p_sync_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !is_last |=> !sync_q);

endmodule

// File: rtl/cellcmd_reply.sv
module cellcmd_reply
  import cellcmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req,
  input  byte_t my_addr,
  input  byte_t status,
  input  logic  rdy,
  output logic  valid,
  output byte_t data
);

  rpl_state_e st_q;
  byte_t      addr_q;
  byte_t      stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RPL_IDLE;
      addr_q <= '0;
      stat_q <= '0;
    end else begin
      unique case (st_q)
        RPL_IDLE: if (req) begin
          st_q   <= RPL_ADDR;
          addr_q <= my_addr;
          stat_q <= status;
        end
        RPL_ADDR: if (rdy) st_q <= RPL_STAT;
        RPL_STAT: if (rdy) st_q <= RPL_IDLE;
        default:  st_q <= RPL_IDLE;
      endcase
    end
  end

  assign valid = (st_q != RPL_IDLE);
  assign data  = (st_q == RPL_STAT) ? stat_q : addr_q;

  p_rpl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !rdy) |=> (valid && $stable(data)));

  p_rpl_second_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RPL_ADDR && rdy) |=> valid);

  p_rpl_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RPL_STAT && rdy) |=> !valid);

endmodule

// File: rtl/cellcmd_rx.sv
module cellcmd_rx
  import cellcmd_pkg::*;
#(
  parameter int CMP_W = 16,
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       my_addr,
  input  logic [GAP_W-1:0] gap_limit,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic [CMP_W-1:0] cmp_a,
  output logic [CMP_W-1:0] cmp_b,
  output logic             sync_pulse,
  input  logic             rpl_req,
  input  logic [7:0]       dc_status,
  output logic             rpl_valid,
  input  logic             rpl_ready,
  output logic [7:0]       rpl_data
);

  localparam int PKT_LEN = 2 + 2 * (CMP_W / BYTE_W);
  localparam int IDX_W   = $clog2(PKT_LEN);

  logic [IDX_W-1:0] pos;
  logic             is_last;
  logic             crc_ok;

  // A serial receiver cannot be stalled.
  assign in_ready = 1'b1;

  cellcmd_framer #(.PKT_LEN(PKT_LEN), .GAP_W(GAP_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .gap_limit(gap_limit),
    .pos_q(pos), .is_last(is_last)
  );

  cellcmd_crc #(.PKT_LEN(PKT_LEN)) u_crc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pos(pos),
    .din(in_data), .crc_ok(crc_ok)
  );

  cellcmd_stage #(.CMP_W(CMP_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pos(pos), .din(in_data),
    .is_last(is_last), .crc_ok(crc_ok), .my_addr(my_addr),
    .cmp_a_q(cmp_a), .cmp_b_q(cmp_b), .sync_q(sync_pulse)
  );

  cellcmd_reply u_reply (
    .clk(clk), .rst_n(rst_n), .req(rpl_req), .my_addr(my_addr),
    .status(dc_status), .rdy(rpl_ready), .valid(rpl_valid), .data(rpl_data)
  );

  p_sync_moves_cmp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(cmp_a) |-> sync_pulse);

endmodule

// File: tb/cellcmd_rx_tb.sv
module cellcmd_rx_tb_top;

  localparam int CLK_NS = 10;
  localparam int WDOG_CYC = 100000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  my_addr = 8'h2A;
  logic [15:0] gap_limit = 16'd4;
  logic        in_valid = 0;
  logic        in_ready;
  logic [7:0]  in_data = 0;
  logic [15:0] cmp_a, cmp_b;
  logic        sync_pulse;
  logic        rpl_req = 0;
  logic [7:0]  dc_status = 0;
  logic        rpl_valid;
  logic        rpl_ready = 0;
  logic [7:0]  rpl_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  cellcmd_rx dut_i (
    .clk(clk), .rst_n(rst_n), .my_addr(my_addr), .gap_limit(gap_limit),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .sync_pulse(sync_pulse),
    .rpl_req(rpl_req), .dc_status(dc_status), .rpl_valid(rpl_valid),
    .rpl_ready(rpl_ready), .rpl_data(rpl_data)
  );

  function automatic logic [7:0] crc_ref(input logic [7:0] b [5]);
    logic [7:0] c = 8'h00;
    for (int k = 0; k < 5; k++) begin
      for (int i = 7; i >= 0; i--) begin
        logic fb = c[7] ^ b[k][i];
        c = {c[6:0], 1'b0};
        if (fb) c = c ^ 8'h07;
      end
    end
    return c;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge.
  logic [7:0]  mq[$];
  int          m_idle = 0;
  logic [15:0] m_a = 0, m_b = 0;
  logic        m_sync = 0;
  bit          m_busy = 0;
  int          m_stage = 0;
  logic [7:0]  m_raddr = 0, m_rstat = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_idle = 0; m_a = 0; m_b = 0; m_sync = 0;
      m_busy = 0; m_stage = 0;
    end else begin
      m_sync = 0;
      if (in_valid) begin
        mq.push_back(in_data);
        m_idle = 0;
        if (mq.size() == 6) begin
          logic [7:0] b5 [5];
          for (int k = 0; k < 5; k++) b5[k] = mq[k];
          if (crc_ref(b5) == mq[5] && mq[0] == my_addr) begin
            m_a = {mq[1], mq[2]};
            m_b = {mq[3], mq[4]};
            m_sync = 1;
          end
          mq.delete();
        end
      end else if (mq.size() > 0) begin
        m_idle++;
        if (m_idle > int'(gap_limit)) begin
          mq.delete();
          m_idle = 0;
        end
      end
      if (m_busy) begin
        if (rpl_ready) begin
          if (m_stage == 0) m_stage = 1;
          else m_busy = 0;
        end
      end else if (rpl_req) begin
        m_busy = 1; m_stage = 0; m_raddr = my_addr; m_rstat = dc_status;
      end
    end
  end

  int sync_seen = 0;
  int hs_cnt = 0;
  logic [7:0] hs_bytes[$];

  // Clock-by-clock comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1 in_ready", 32'(in_ready), 32'd1);
      check("R5 cmp_a", 32'(cmp_a), 32'(m_a));
      check("R5 cmp_b", 32'(cmp_b), 32'(m_b));
      check("R6 sync_pulse", 32'(sync_pulse), 32'(m_sync));
      check("R8 rpl_valid", 32'(rpl_valid), 32'(m_busy));
      if (m_busy)
        check("R8 rpl_data", 32'(rpl_data), 32'(m_stage == 0 ? m_raddr : m_rstat));
      if (sync_pulse) sync_seen++;
      if (rpl_valid && rpl_ready) begin
        hs_cnt++;
        hs_bytes.push_back(rpl_data);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    in_valid = 1; in_data = b;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic send_pkt(input logic [7:0] addr, input logic [15:0] a,
                          input logic [15:0] b, input bit bad_crc, input int gap);
    logic [7:0] p [5];
    logic [7:0] c;
    p[0] = addr; p[1] = a[15:8]; p[2] = a[7:0]; p[3] = b[15:8]; p[4] = b[7:0];
    c = crc_ref(p) ^ (bad_crc ? 8'h01 : 8'h00);
    for (int k = 0; k < 5; k++) begin
      send_byte(p[k]);
      idle(gap);
    end
    send_byte(c);
  endtask

  initial begin
    int s0;
    idle(3);
    rst_n = 1;
    idle(1);
    // R10 reset state
    check("R10 cmp_a", 32'(cmp_a), 0);
    check("R10 cmp_b", 32'(cmp_b), 0);
    check("R10 sync", 32'(sync_pulse), 0);
    check("R10 rpl_valid", 32'(rpl_valid), 0);

    // R2/R5/R6 good back-to-back packet
    s0 = sync_seen;
    send_pkt(8'h2A, 16'h1234, 16'hABCD, 0, 0);
    idle(1);
    check("R5 cmp_a good", 32'(cmp_a), 32'h1234);
    check("R5 cmp_b good", 32'(cmp_b), 32'hABCD);
    check("R6 one strobe", sync_seen - s0, 1);

    // R2/R4 corrupted CRC
    s0 = sync_seen;
    send_pkt(8'h2A, 16'h5555, 16'h6666, 1, 0);
    idle(2);
    check("R2 bad crc cmp_a", 32'(cmp_a), 32'h1234);
    check("R4 bad crc no strobe", sync_seen - s0, 0);

    // R3 wrong address
    send_pkt(8'h2B, 16'h7070, 16'h0707, 0, 1);
    idle(2);
    check("R3 foreign addr cmp_b", 32'(cmp_b), 32'hABCD);

    // R7 gaps exactly at the limit are tolerated
    send_pkt(8'h2A, 16'h0F0F, 16'hF0F0, 0, 4);
    idle(1);
    check("R7 gap at limit", 32'(cmp_a), 32'h0F0F);

    // R7 stale partial discarded after limit+1 idle cycles
    send_byte(8'h2A); send_byte(8'h99); send_byte(8'h98);
    idle(5);
    send_pkt(8'h2A, 16'h7777, 16'h8888, 0, 0);
    idle(1);
    check("R7 partial dropped", 32'(cmp_a), 32'h7777);

    // R7 gap one over the limit breaks a packet
    s0 = sync_seen;
    send_pkt(8'h2A, 16'h4321, 16'h1111, 0, 5);
    idle(8);
    check("R7 gap over limit", sync_seen - s0, 0);
    check("R7 gap over limit cmp", 32'(cmp_a), 32'h7777);

    // R2 zero payload, CRC value also exercised with limit 0
    gap_limit = 16'd0;
    send_pkt(8'h2A, 16'h0000, 16'hFFFF, 0, 0);
    idle(1);
    check("R2 zero payload", 32'(cmp_b), 32'hFFFF);
    gap_limit = 16'd4;

    // R8/R9 reply with back-pressure and ignored requests
    dc_status = 8'h5A;
    rpl_req = 1; @(negedge clk); rpl_req = 0;
    dc_status = 8'hC3;
    idle(2);
    rpl_req = 1; @(negedge clk); rpl_req = 0;
    rpl_ready = 1;
    @(negedge clk);
    rpl_req = 1; @(negedge clk); rpl_req = 0;
    rpl_ready = 0;
    idle(3);
    check("R9 byte count", hs_cnt, 2);
    check("R8 first byte addr", 32'(hs_bytes[0]), 32'h2A);
    check("R8 second byte status", 32'(hs_bytes[1]), 32'h5A);

    // Mixed random traffic against the model
    for (int n = 0; n < 40; n++) begin
      logic [7:0] ad;
      ad = ($urandom % 4 == 0) ? 8'h2B : 8'h2A;
      send_pkt(ad, 16'($urandom), 16'($urandom), ($urandom % 5) == 0, $urandom % 6);
      idle($urandom % 3);
    end
    idle(4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < WDOG_CYC; c++) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule